// File: doc/BRIEF.md
# Linear Burst Address Strobe Controller

This block sequences the address phase of a bus master that moves data in linear bursts. A requester opens an access stream with a start pulse, an access type and a start address. The controller then issues a one-cycle address strobe that carries the current address. Each completed transfer is signalled by the ready input, and on each one the controller moves the address forward by one 32-bit word. Inside a burst a new strobe goes out only when the decoded transfer limit has been reached. Outside a burst every transfer gets its own strobe. The stream ends when the requester or the bus raises the terminate input, or on a soft reset.

A small control register holds a write-burst enable bit and a 3-bit burst-size code. The code is decoded by shifting its highest set bit left by two places, so the limit is 4, 8 or 16 transfers. The decoded value is only an upper limit, because a terminate can end the stream sooner. An external enable pin can lock write bursting off. Descriptor and initialization accesses are never burst. Data reads burst under a separate enable input.

Top module: `lburst_strobe_ctrl`

## Requirements
- R1: After hard reset (rst_n low), ads, busy and burst_act are 0, and the readback of the burst-size code and the write-burst enable bit are 0.
- R2: A cycle with cfg_we high loads cfg_wdata[2:0] into the burst-size code and cfg_wdata[3] into the write-burst enable bit. Both are visible on the readback ports in the next cycle.
- R3: While burst_pin is low, the write-burst enable bit reads 0 and writes to it have no effect. Raising the pin again does not restore an earlier value.
- R4: A soft_rst cycle ends any stream, so busy is 0 in the next cycle. It leaves the burst-size code and the write-burst enable bit unchanged.
- R5: A start pulse accepted while idle makes ads high in the next cycle, for exactly one cycle, with addr equal to start_addr. The start is accepted only while busy is 0.
- R6: Each ready pulse after the strobe, without terminate, moves addr forward by 4.
- R7: The burst limit is 4 shifted left by the index of the highest set bit of the code: 001 gives 4, 010 gives 8, 100 gives 16, 011 gives 8 and 111 gives 16. After that many transfers in a burst, a new strobe is issued with the next address.
- R8: Code 000 disables bursting, so every transfer gets its own strobe.
- R9: Descriptor accesses (type 2'b10) and initialization accesses (type 2'b11) never burst, whatever the register settings.
- R10: Data writes (type 2'b01) burst only when the write-burst enable bit is set. Data reads (type 2'b00) burst only when rd_burst_en is high.
- R11: Terminate during a stream makes busy 0 in the next cycle, even when the limit has not been reached.
- R12: burst_act is high during every cycle of a stream that runs in burst mode, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Soft reset or stop: aborts the stream and keeps the configuration |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Bit 3 is the write-burst enable, bits 2:0 are the burst-size code |
| burst_pin | input | 1 | External pin; when low it locks write bursting off |
| rd_burst_en | input | 1 | Enable for read bursting |
| start | input | 1 | Opens an access stream |
| start_type | input | 2 | 00 data read, 01 data write, 10 descriptor, 11 initialization |
| start_addr | input | 32 | First address of the stream |
| rdy | input | 1 | Transfer completion handshake |
| term | input | 1 | Ends the stream early |
| ads | output | 1 | Address strobe, one cycle |
| addr | output | 32 | Current transfer address |
| busy | output | 1 | A stream is open |
| burst_act | output | 1 | The open stream runs in burst mode |
| cfg_code | output | 3 | Readback of the burst-size code |
| cfg_bwen | output | 1 | Readback of the write-burst enable bit |

## Verification
The bench targets the limit decode for every code. This includes codes with more than one set bit: a design that used the lowest set bit, or did not shift, would put strobes at the wrong spacing. It also checks the lock from the enable pin, where a leak would let a write burst or bring back a stale enable after the pin rises. The bench checks that descriptor and initialization types never burst, since a design that got this wrong would hold back strobes for them. It also checks a terminate before the limit and a soft reset in the middle of a burst: a faulty design would keep busy high or lose the register contents.

// File: rtl/lburst_pkg.sv
package lburst_pkg;

  typedef enum logic [1:0] {
    ACC_DRD  = 2'b00,
    ACC_DWR  = 2'b01,
    ACC_DESC = 2'b10,
    ACC_INIT = 2'b11
  } acc_type_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_STRB = 2'b01,
    SQ_XFER = 2'b10
  } seq_state_e;

  // Decoded burst limit: the highest set code bit, moved up by the shift.
  // Returns 0 when no bit is set.
  function automatic int unsigned lb_limit(input logic [7:0] code,
                                           input int unsigned nbits,
                                           input int unsigned shift);
    int unsigned lim;
    lim = 0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < nbits && code[i]) lim = 32'd1 << (i + shift);
    end
    return lim;
  endfunction

  // Whether an access type may burst under the current enables.
  function automatic logic lb_type_ok(input acc_type_e t,
                                      input logic wr_en,
                                      input logic rd_en);
    case (t)
      ACC_DRD: return rd_en;
      ACC_DWR: return wr_en;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lburst_cfg_reg.sv
module lburst_cfg_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W:0]   wdata,
  input  logic              pin,
  output logic [CODE_W-1:0] code_q,
  output logic              bwen_q
);

  // Named events for the checks below.
  logic ev_bwen_load;
  logic ev_bwen_lock;
  assign ev_bwen_load = we && pin;
  assign ev_bwen_lock = !pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bwen_q <= 1'b0;
    end else begin
      if (we) code_q <= wdata[CODE_W-1:0];
      if (ev_bwen_lock)      bwen_q <= 1'b0;
      else if (ev_bwen_load) bwen_q <= wdata[CODE_W];
    end
  end

  assert_bwen_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pin |=> !bwen_q);

  assert_code_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> code_q == $past(wdata[CODE_W-1:0]));

  assert_bwen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && pin) |=> bwen_q == $past(bwen_q) || !$past(pin));

endmodule

// File: rtl/lburst_limit_dec.sv
module lburst_limit_dec
  import lburst_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int SHIFT  = 2,
  parameter int CNT_W  = CODE_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        acc_type,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [CNT_W-1:0]  limit,
  output logic              eligible
);

  logic [7:0]  code_ext;
  int unsigned raw_lim;
  logic        type_ok;

  always_comb begin
    code_ext = 8'(code);
    raw_lim  = lb_limit(code_ext, CODE_W, SHIFT);
    type_ok  = lb_type_ok(acc_type_e'(acc_type), wr_en, rd_en);
    eligible = type_ok && (raw_lim != 0);
    limit    = eligible ? CNT_W'(raw_lim) : CNT_W'(1);
  end

  assert_ctrl_type_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type[1] |-> !eligible && limit == CNT_W'(1));

  assert_zero_code_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> !eligible);

  assert_limit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eligible |-> $onehot0(limit) && limit >= CNT_W'(4));

endmodule

// File: rtl/lburst_seq.sv
module lburst_seq
  import lburst_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 5,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] lim_in,
  input  logic             burst_in,
  input  logic             rdy,
  input  logic             term,
  output logic             ads,
  output logic             busy,
  output logic             burst_act,
  output logic [AW-1:0]    addr
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(STEP);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             burst_q;
  logic [AW-1:0]    addr_q;

  // Internal events, named for the checks.
  logic             ev_launch;
  logic             ev_done;
  logic             ev_wrap;
  logic             ev_abort;
  logic [CNT_W-1:0] cnt_nx;

  assign ev_launch = (st_q == SQ_IDLE) && start;
  assign ev_abort  = (st_q != SQ_IDLE) && term;
  assign ev_done   = (st_q == SQ_XFER) && rdy && !term;
  assign cnt_nx    = cnt_q + CNT_W'(1);
  assign ev_wrap   = ev_done && (cnt_nx >= lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      lim_q   <= CNT_W'(1);
      burst_q <= 1'b0;
      addr_q  <= '0;
    end else if (soft_rst) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (ev_launch) begin
            st_q    <= SQ_STRB;
            addr_q  <= start_addr;
            lim_q   <= lim_in;
            burst_q <= burst_in;
            cnt_q   <= '0;
          end
        end
        SQ_STRB: begin
          if (ev_abort) st_q <= SQ_IDLE;
          else          st_q <= SQ_XFER;
        end
        SQ_XFER: begin
          if (ev_abort) begin
            st_q    <= SQ_IDLE;
            burst_q <= 1'b0;
          end else if (ev_done) begin
            addr_q <= addr_q + ADDR_STEP;
            if (ev_wrap) begin
              cnt_q <= '0;
              st_q  <= SQ_STRB;
            end else begin
              cnt_q <= cnt_nx;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ads       = (st_q == SQ_STRB);
  assign busy      = (st_q != SQ_IDLE);
  assign burst_act = busy && burst_q;
  assign addr      = addr_q;

  assert_ads_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ads |=> !ads);

  assert_launch_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_launch && !soft_rst) |=> ads && addr == $past(start_addr));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !soft_rst) |=> addr == $past(addr) + ADDR_STEP);

  assert_term_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !busy);

  assert_soft_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q < lim_q);

  assert_wrap_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap && !soft_rst) |=> ads);

endmodule

// File: rtl/lburst_strobe_ctrl.sv
module lburst_strobe_ctrl
  import lburst_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CODE_W = 3,
  parameter int SHIFT  = 2,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [CODE_W:0]   cfg_wdata,
  input  logic              burst_pin,
  input  logic              rd_burst_en,
  input  logic              start,
  input  logic [1:0]        start_type,
  input  logic [AW-1:0]     start_addr,
  input  logic              rdy,
  input  logic              term,
  output logic              ads,
  output logic [AW-1:0]     addr,
  output logic              busy,
  output logic              burst_act,
  output logic [CODE_W-1:0] cfg_code,
  output logic              cfg_bwen
);

  localparam int CNT_W = CODE_W + SHIFT;

  logic [CNT_W-1:0] dec_limit;
  logic             dec_elig;

  lburst_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .pin    (burst_pin),
    .code_q (cfg_code),
    .bwen_q (cfg_bwen)
  );

  lburst_limit_dec #(.CODE_W(CODE_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (cfg_code),
    .acc_type (start_type),
    .wr_en    (cfg_bwen),
    .rd_en    (rd_burst_en),
    .limit    (dec_limit),
    .eligible (dec_elig)
  );

  lburst_seq #(.AW(AW), .CNT_W(CNT_W), .STEP(STEP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .start      (start),
    .start_addr (start_addr),
    .lim_in     (dec_limit),
    .burst_in   (dec_elig),
    .rdy        (rdy),
    .term       (term),
    .ads        (ads),
    .busy       (busy),
    .burst_act  (burst_act),
    .addr       (addr)
  );

  assert_soft_keeps_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !cfg_we && burst_pin) |=> cfg_code == $past(cfg_code) && cfg_bwen == $past(cfg_bwen));

  assert_busy_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act |-> busy);

endmodule

// File: tb/lburst_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module lburst_strobe_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        burst_pin = 1'b1;
  logic        rd_burst_en = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  start_type = 2'b00;
  logic [31:0] start_addr = '0;
  logic        rdy = 1'b0;
  logic        term = 1'b0;
  logic        ads;
  logic [31:0] addr;
  logic        busy;
  logic        burst_act;
  logic [2:0]  cfg_code;
  logic        cfg_bwen;

  always #10 clk = ~clk;

  lburst_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .burst_pin(burst_pin), .rd_burst_en(rd_burst_en),
    .start(start), .start_type(start_type), .start_addr(start_addr),
    .rdy(rdy), .term(term), .ads(ads), .addr(addr), .busy(busy),
    .burst_act(burst_act), .cfg_code(cfg_code), .cfg_bwen(cfg_bwen)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit go = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: integer state, 0 idle, 1 strobe, 2 transferring.
  int          m_st = 0;
  int          m_cnt = 0;
  int          m_lim = 1;
  bit          m_burst = 0;
  longint      m_addr = 0;
  bit          m_bwen = 0;
  bit [2:0]    m_code = 0;

  function automatic int size_of(input bit [2:0] c);
    if (c[2]) return 16;
    if (c[1]) return 8;
    if (c[0]) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lim = 1; m_burst = 0; m_addr = 0; m_bwen = 0; m_code = 0;
    end else begin
      if (soft_rst) begin
        m_st = 0; m_cnt = 0; m_burst = 0;
      end else if (m_st == 0) begin
        if (start) begin
          bit may;
          may = (start_type == 2'b00) ? rd_burst_en :
                (start_type == 2'b01) ? m_bwen : 1'b0;
          m_burst = may && size_of(m_code) != 0;
          m_lim = m_burst ? size_of(m_code) : 1;
          m_addr = start_addr;
          m_cnt = 0;
          m_st = 1;
        end
      end else if (term) begin
        m_st = 0; m_burst = 0;
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (rdy) begin
        m_addr = (m_addr + 4) & 64'hFFFF_FFFF;
        m_cnt++;
        if (m_cnt >= m_lim) begin
          m_cnt = 0;
          m_st = 1;
        end
      end
      if (!burst_pin) m_bwen = 0;
      else if (cfg_we) m_bwen = cfg_wdata[3];
      if (cfg_we) m_code = cfg_wdata[2:0];
    end
  end

  int ads_seen = 0;
  int ba_seen = 0;

  always @(negedge clk) begin
    if (go) begin
      check(ads == (m_st == 1), "R5 ads", ads, m_st == 1);
      check(busy == (m_st != 0), "R11 busy", busy, m_st != 0);
      check(burst_act == (m_st != 0 && m_burst), "R12 burst_act", burst_act, m_st != 0 && m_burst);
      if (m_st != 0) check(addr == m_addr[31:0], "R6 addr", addr, m_addr);
      check(cfg_code == m_code, "R2 cfg_code", cfg_code, m_code);
      check(cfg_bwen == m_bwen, "R3 cfg_bwen", cfg_bwen, m_bwen);
      if (ads) ads_seen++;
      if (burst_act) ba_seen++;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_cfg(input bit [3:0] d);
    cfg_we = 1'b1; cfg_wdata = d; tick(); cfg_we = 1'b0; tick();
  endtask

  // Stream with ready held high for w observed cycles, then terminate.
  task automatic stream(input bit [1:0] t, input bit [31:0] a, input int w,
                        input int lim, input string req);
    int s_ads, s_ba;
    start = 1'b1; start_type = t; start_addr = a; tick();
    start = 1'b0; rdy = 1'b1; ads_seen = 0; ba_seen = 0;
    repeat (w) tick();
    s_ads = ads_seen; s_ba = ba_seen;
    rdy = 1'b0; term = 1'b1; tick(); term = 1'b0;
    @(negedge clk); #1;
    check(busy == 1'b0, "R11 idle after term", busy, 0);
    check(s_ads == (w + lim) / (lim + 1), req, s_ads, (w + lim) / (lim + 1));
    check((s_ba != 0) == (lim > 1), {req, " R12 burst mode"}, s_ba, (lim > 1) ? w : 0);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    go = 1;
    @(negedge clk); #1;
    check(ads == 0 && busy == 0 && burst_act == 0, "R1 outputs", {ads, busy, burst_act}, 0);
    check(cfg_code == 0 && cfg_bwen == 0, "R1 cfg", {cfg_bwen, cfg_code}, 0);
    tick();

    wr_cfg(4'b1010);
    @(negedge clk); #1;
    check(cfg_code == 3'b010 && cfg_bwen, "R2 readback", {cfg_bwen, cfg_code}, 4'b1010);
    tick();

    stream(2'b01, 32'h1000, 27, 8, "R7 write code 010");
    wr_cfg(4'b1001); stream(2'b01, 32'h2000, 15, 4, "R7 code 001");
    wr_cfg(4'b1100); stream(2'b01, 32'h3000, 51, 16, "R7 code 100");
    wr_cfg(4'b1011); stream(2'b01, 32'h4000, 18, 8, "R7 code 011 highest bit");
    wr_cfg(4'b1111); stream(2'b01, 32'h5000, 34, 16, "R7 code 111 highest bit");
    wr_cfg(4'b1000); stream(2'b01, 32'h6000, 7, 1, "R8 code 000");

    wr_cfg(4'b1010);
    stream(2'b10, 32'h7000, 8, 1, "R9 descriptor");
    stream(2'b11, 32'h7100, 8, 1, "R9 init");
    rd_burst_en = 1'b0; stream(2'b00, 32'h8000, 8, 1, "R10 read disabled");
    rd_burst_en = 1'b1; stream(2'b00, 32'h8100, 18, 8, "R10 read enabled");
    wr_cfg(4'b0010);  stream(2'b01, 32'h8200, 8, 1, "R10 write disabled");

    wr_cfg(4'b1010);
    burst_pin = 1'b0; tick();
    @(negedge clk); #1;
    check(cfg_bwen == 0, "R3 pin forces zero", cfg_bwen, 0);
    tick();
    wr_cfg(4'b1010);
    @(negedge clk); #1;
    check(cfg_bwen == 0, "R3 write ignored", cfg_bwen, 0);
    tick();
    stream(2'b01, 32'h9000, 8, 1, "R3 locked write");
    burst_pin = 1'b1; tick(); tick();
    @(negedge clk); #1;
    check(cfg_bwen == 0, "R3 no restore", cfg_bwen, 0);
    tick();

    // Irregular ready with an early terminate, compared by the model.
    wr_cfg(4'b1100);
    start = 1'b1; start_type = 2'b01; start_addr = 32'hFFFF_FFF0; tick(); start = 1'b0;
    for (int i = 0; i < 9; i++) begin rdy = (i % 3 != 0); tick(); end
    rdy = 1'b1; term = 1'b1; tick(); rdy = 1'b0; term = 1'b0;
    @(negedge clk); #1;
    check(busy == 0, "R11 early term", busy, 0);
    tick();

    // Soft reset in the middle of a burst.
    start = 1'b1; start_type = 2'b01; start_addr = 32'hA000; tick(); start = 1'b0;
    rdy = 1'b1; repeat (4) tick();
    soft_rst = 1'b1; tick(); soft_rst = 1'b0; rdy = 1'b0;
    @(negedge clk); #1;
    check(busy == 0, "R4 soft aborts", busy, 0);
    check(cfg_code == 3'b100 && cfg_bwen, "R4 cfg kept", {cfg_bwen, cfg_code}, 4'b1100);
    tick();

    // Start while busy is ignored.
    start = 1'b1; start_addr = 32'hB000; tick(); start_addr = 32'hC000; tick(); start = 1'b0;
    @(negedge clk); #1;
    check(addr == 32'hB000, "R5 start ignored while busy", addr, 32'hB000);
    term = 1'b1; tick(); term = 1'b0; tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule